// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a gate window of known length. The gate is timed in periods of a reference tick, where one tick stands for one millisecond. The count, divided by the gate time, gives the frequency. For example, 342400 edges in a 32-tick gate means 10.7 MHz.

Control comes from a serial write frame. When the frame is latched, the block is given a run bit, a two-bit gate selector and an input-sensitivity bit. The sensitivity bit is only stored and passed on. If the latched run bit is 0, the counter is held cleared. A latched change of the run bit from 0 to 1 starts a measurement. The block first waits a settling interval whose length depends on the gate selector. It then opens the gate and counts. When the gate closes, it raises a done flag and freezes the result.

The result can be shifted out serially, MSB first. A completion status output is also available when the system selects it. This output is released when a measurement starts, is pulled low when the measurement ends, and is released again on any serial access.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `result` is 0, and `done` and `stat_low` are both low.
- R2: `gate_sel` is latched at the start of a measurement and sets the gate length in reference ticks: 0 gives 8 ticks, 1 gives 16, 2 gives 32 and 3 gives 64. `done` stays low until the final gate tick and is high in the cycle after that tick is sampled.
- R3: Before the gate opens there is a settling wait. It lasts 4 ticks when `gate_sel` is 0 or 1, and 8 ticks when it is 2 or 3. Input edges during the wait are not counted.
- R4: Each rising edge of `if_in` inside the gate adds one to `result`, after a two-flop synchroniser. Once `done` is high, `result` holds its value and further edges have no effect.
- R5: A measurement starts only on a `cfg_load` pulse with `run_in`=1 when the previously latched run bit was 0. If a `cfg_load` arrives with `run_in`=1 while the run bit is already 1, `result` and `done` are left unchanged.
- R6: A `cfg_load` pulse with `run_in`=0 clears `result` to 0 and `done` to low in the next cycle.
- R7: `result` saturates at its all-ones value and never wraps.
- R8: `stat_low` can only be high while `stat_sel`=1. With `stat_sel`=1, `stat_low` is low after a start and goes high when `done` rises. It returns low in the cycle after `ce_hi` is high.
- R9: A `rd_load` pulse captures `result`. `rd_bit` then presents the MSB, and each `rd_shift` pulse moves on to the next lower bit.
- R10: `sens_out` takes the value of `sens_in` at each `cfg_load` and keeps it in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_in | input | 1 | Asynchronous IF pulse input |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| cfg_load | input | 1 | Frame latch strobe |
| run_in | input | 1 | Run bit carried by the frame |
| gate_sel | input | 2 | Gate length selector carried by the frame |
| sens_in | input | 1 | Input-sensitivity bit carried by the frame |
| stat_sel | input | 1 | Enables completion signalling on `stat_low` |
| ce_hi | input | 1 | Serial access in progress |
| rd_load | input | 1 | Capture the result into the readout register |
| rd_shift | input | 1 | Shift the readout register by one bit |
| result | output | CNT_W | Current or held count |
| done | output | 1 | Measurement complete |
| stat_low | output | 1 | Drive the status line low |
| rd_bit | output | 1 | Serial readout bit, MSB first |
| sens_out | output | 1 | Latched sensitivity bit |

## Verification
The assertions check every cycle for the following: the count never wraps at all-ones, the count never decreases except on a frame latch, the result is frozen while `done` is high, a stop latch clears the block, and the status line is only held low while `done` is high and is released after a serial access. Three properties need the bench's timed scenarios, because they depend on the exact placement of ticks and edges: the wait and gate lengths for each selector, the exclusion of edges during the settling wait, and the MSB-first readout. A second instance with a 6-bit counter lets the bench reach saturation within a short run.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GATE = 2'd2,
    PH_DONE = 2'd3
  } ifc_phase_e;
endpackage

// File: rtl/ifc_sync.sv
module ifc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ifc_seq.sv
module ifc_seq
  import ifc_pkg::*;
#(
  parameter int unsigned BASE_GATE  = 8,
  parameter int unsigned SHORT_WAIT = 4,
  parameter int unsigned LONG_WAIT  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       run_in,
  input  logic [1:0] gate_sel,
  input  logic       ref_tick,
  output ifc_phase_e phase,
  output logic       start,
  output logic       stop,
  output logic       finish
);
  localparam int unsigned TW = $clog2(BASE_GATE * 8 + 1);

  ifc_phase_e    phase_q, phase_d;
  logic [TW-1:0] left_q, left_d;
  logic [1:0]    sel_q, sel_d;
  logic          run_q, run_d;
  logic          last_tick;

  function automatic logic [TW-1:0] gate_len(input logic [1:0] s);
    return TW'(BASE_GATE) << s;
  endfunction

  function automatic logic [TW-1:0] wait_len(input logic [1:0] s);
    return s[1] ? TW'(LONG_WAIT) : TW'(SHORT_WAIT);
  endfunction

  assign start     = cfg_load & run_in & ~run_q;
  assign stop      = cfg_load & ~run_in;
  assign last_tick = ref_tick & (left_q == TW'(1));
  assign finish    = (phase_q == PH_GATE) & last_tick & ~start & ~stop;

  always_comb begin
    phase_d = phase_q;
    left_d  = left_q;
    sel_d   = sel_q;
    run_d   = cfg_load ? run_in : run_q;
    if (stop) begin
      phase_d = PH_IDLE;
    end else if (start) begin
      phase_d = PH_WAIT;
      left_d  = wait_len(gate_sel);
      sel_d   = gate_sel;
    end else begin
      unique case (phase_q)
        PH_WAIT: if (ref_tick) begin
          if (last_tick) begin
            phase_d = PH_GATE;
            left_d  = gate_len(sel_q);
          end else begin
            left_d = left_q - TW'(1);
          end
        end
        PH_GATE: if (ref_tick) begin
          if (last_tick) phase_d = PH_DONE;
          else           left_d  = left_q - TW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      sel_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
      sel_q   <= sel_d;
      run_q   <= run_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/ifc_accum.sv
module ifc_accum #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] val_q, val_d;
  logic         full;

  assign full = &val_q;

  always_comb begin
    val_d = val_q;
    if (clr)                   val_d = '0;
    else if (en & inc & ~full) val_d = val_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter
  import ifc_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BASE_GATE   = 8,
  parameter int unsigned SHORT_WAIT  = 4,
  parameter int unsigned LONG_WAIT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_in,
  input  logic             ref_tick,
  input  logic             cfg_load,
  input  logic             run_in,
  input  logic [1:0]       gate_sel,
  input  logic             sens_in,
  input  logic             stat_sel,
  input  logic             ce_hi,
  input  logic             rd_load,
  input  logic             rd_shift,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             stat_low,
  output logic             rd_bit,
  output logic             sens_out
);
  ifc_phase_e       phase;
  logic             start, stop, finish, edge_seen;
  logic             flag_q, flag_d, sens_q, sens_d;
  logic [CNT_W-1:0] shreg_q, shreg_d;

  ifc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(if_in), .rise(edge_seen)
  );

  ifc_seq #(
    .BASE_GATE(BASE_GATE), .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .run_in(run_in),
    .gate_sel(gate_sel), .ref_tick(ref_tick), .phase(phase),
    .start(start), .stop(stop), .finish(finish)
  );

  ifc_accum #(.W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(start | stop),
    .en(phase == PH_GATE), .inc(edge_seen), .value(result)
  );

  always_comb begin
    flag_d = flag_q;
    if (ce_hi | cfg_load) flag_d = 1'b0;
    else if (finish)      flag_d = 1'b1;
    sens_d  = cfg_load ? sens_in : sens_q;
    shreg_d = shreg_q;
    if (rd_load)       shreg_d = result;
    else if (rd_shift) shreg_d = shreg_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      sens_q  <= 1'b0;
      shreg_q <= '0;
    end else begin
      flag_q  <= flag_d;
      sens_q  <= sens_d;
      shreg_q <= shreg_d;
    end
  end

  assign done     = (phase == PH_DONE);
  assign stat_low = flag_q & stat_sel;
  assign rd_bit   = shreg_q[CNT_W-1];
  assign sens_out = sens_q;
endmodule

// File: rtl/if_gate_counter_chk.sv
module if_gate_counter_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_load,
  input logic         run_in,
  input logic         ce_hi,
  input logic         stat_sel,
  input logic [W-1:0] result,
  input logic         done,
  input logic         stat_low
);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((&result) && !cfg_load) |=> (&result));

  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> (result >= $past(result)));

  a_r4_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_load) |=> $stable(result));

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !run_in) |=> (result == '0 && !done));

  a_r8_release_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    ce_hi |=> !stat_low);

  a_r8_low_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_low |-> (done && stat_sel));
endmodule

bind if_gate_counter if_gate_counter_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .run_in(run_in),
  .ce_hi(ce_hi), .stat_sel(stat_sel), .result(result), .done(done),
  .stat_low(stat_low)
);

// File: tb/test_if_gate_counter.sv
module test_if_gate_counter;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CLKS  = 40;
  localparam int NW         = 6;

  logic clk = 1'b0;
  logic rst_n, if_in, ref_tick, cfg_load, run_in, sens_in, stat_sel;
  logic ce_hi, rd_load, rd_shift;
  logic [1:0]    gate_sel;
  logic [19:0]   result;
  logic [NW-1:0] result_n;
  logic done, stat_low, rd_bit, sens_out;
  logic done_n, stat_low_n, rd_bit_n, sens_out_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  if_gate_counter i_if_gate_counter (
    .clk(clk), .rst_n(rst_n), .if_in(if_in), .ref_tick(ref_tick),
    .cfg_load(cfg_load), .run_in(run_in), .gate_sel(gate_sel),
    .sens_in(sens_in), .stat_sel(stat_sel), .ce_hi(ce_hi),
    .rd_load(rd_load), .rd_shift(rd_shift), .result(result), .done(done),
    .stat_low(stat_low), .rd_bit(rd_bit), .sens_out(sens_out)
  );

  if_gate_counter #(.CNT_W(NW)) i_if_gate_counter_narrow (
    .clk(clk), .rst_n(rst_n), .if_in(if_in), .ref_tick(ref_tick),
    .cfg_load(cfg_load), .run_in(run_in), .gate_sel(gate_sel),
    .sens_in(sens_in), .stat_sel(stat_sel), .ce_hi(ce_hi),
    .rd_load(rd_load), .rd_shift(rd_shift), .result(result_n), .done(done_n),
    .stat_low(stat_low_n), .rd_bit(rd_bit_n), .sens_out(sens_out_n)
  );

  function automatic int sat(input int v, input int w);
    int top = (1 << w) - 1;
    return (v > top) ? top : v;
  endfunction

  function automatic int wait_ticks(input logic [1:0] s);
    return s[1] ? 8 : 4;
  endfunction

  function automatic int gate_ticks(input logic [1:0] s);
    return 8 << s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic latch(input logic run, input logic [1:0] sel, input logic sens);
    run_in = run; gate_sel = sel; sens_in = sens; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic pulse();
    if_in = 1'b1; step(); step();
    if_in = 1'b0; step(); step();
  endtask

  task automatic period_body(input int n);
    repeat (4) step();
    for (int k = 0; k < n; k++) pulse();
    repeat (TICK_CLKS - 5 - 4*n) step();
  endtask

  task automatic tick();
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
  endtask

  task automatic measure(input logic [1:0] sel, input int fixed_n, output int exp);
    int w = wait_ticks(sel);
    int g = gate_ticks(sel);
    exp = 0;
    latch(1'b1, sel, 1'b1);
    chk("R8 released at start", int'(stat_low), 0);
    for (int i = 0; i < w + g; i++) begin
      int n = (fixed_n >= 0) ? fixed_n : int'($urandom_range(0, 5));
      period_body(n);
      if (i >= w) exp += n;
      if (i == w + g - 1) chk("R2 done low before last tick", int'(done), 0);
      tick();
    end
    chk("R2 done after gate", int'(done), 1);
    chk("R3 R4 count", int'(result), exp);
    chk("R7 narrow count", int'(result_n), sat(exp, NW));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp;
    logic [19:0] held;
    void'($urandom(32'd2024));
    rst_n = 1'b0; if_in = 1'b0; ref_tick = 1'b0; cfg_load = 1'b0; run_in = 1'b0;
    gate_sel = 2'd0; sens_in = 1'b0; stat_sel = 1'b0; ce_hi = 1'b0;
    rd_load = 1'b0; rd_shift = 1'b0;
    repeat (3) step();
    chk("R1 result", int'(result), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 stat_low", int'(stat_low), 0);
    rst_n = 1'b1;
    step();

    // R10: sensitivity bit follows the latch only
    latch(1'b0, 2'd0, 1'b1);
    chk("R10 sens latched", int'(sens_out), 1);
    sens_in = 1'b0; step();
    chk("R10 sens held", int'(sens_out), 1);

    // status not selected: line never pulled low
    measure(2'd0, 3, exp);
    chk("R8 unselected stays open", int'(stat_low), 0);

    // R4: edges after completion ignored
    pulse(); pulse(); step();
    chk("R4 held after done", int'(result), exp);

    // R5: repeated run=1 latch does not restart
    latch(1'b1, 2'd1, 1'b1);
    step();
    chk("R5 no restart done", int'(done), 1);
    chk("R5 no restart result", int'(result), exp);

    // R6: stop clears
    latch(1'b0, 2'd0, 1'b1);
    chk("R6 cleared result", int'(result), 0);
    chk("R6 cleared done", int'(done), 0);

    // random measurements over all selectors with status signalling
    stat_sel = 1'b1;
    for (int r = 0; r < 6; r++) begin
      logic [1:0] s = 2'(r % 3);
      measure(s, -1, exp);
      chk("R8 low at done", int'(stat_low), 1);
      // R9: serial readout, MSB first
      held = 20'(exp);
      rd_load = 1'b1; step(); rd_load = 1'b0;
      for (int b = 19; b >= 0; b--) begin
        chk("R9 readout bit", int'(rd_bit), int'(held[b]));
        rd_shift = 1'b1; step(); rd_shift = 1'b0;
      end
      ce_hi = 1'b1; step(); ce_hi = 1'b0;
      chk("R8 release on access", int'(stat_low), 0);
      latch(1'b0, 2'd0, 1'b1);
    end

    // longest gate, dense input: narrow instance saturates
    measure(2'd3, 5, exp);
    chk("R7 saturated", int'(result_n), (1 << NW) - 1);
    latch(1'b0, 2'd0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule